// File: doc/BRIEF.md
# Dual-Clock Word-to-Half FIFO with Reset-Selected Byte Order

This block is a first-in first-out channel between two clock domains. A producer writes 36-bit words on the write side; a consumer drains them as 18-bit halves on the read side. The two clocks may be unrelated. Both pointers are kept in gray code and cross into the other domain through two-flop synchronizers. The storage array holds whole words. A read-side sequencer picks which half of the current word goes out next.

One configuration pin, `cfg_sel`, has two jobs. While `mrst` is high it is sampled as the byte order. Once `mrst` falls it selects the read timing. In standard timing a read strobe fetches the next half into `rd_data`. In fall-through timing a one-entry output register fills on its own, and a strobe consumes what it holds. The two flags change meaning with the timing mode.

Each side transfers on a rising edge of its clock when its select is low and its enable is high. A strobe is only a request. Back-pressure is shown by the flags: the write-side flag tells whether a write strobe will be taken, and the read-side flag tells whether read data exists. A strobe made against a full store or against an empty store is dropped.

Top module: `narrowing_fifo`

## Requirements
- R1: If `cfg_sel` is high during master reset (big order), the upper half (bits 35:18) of each word is delivered before the lower half.
- R2: If `cfg_sel` is low during master reset (little order), the lower half (bits 17:0) of each word is delivered before the upper half.
- R3: In standard timing (`cfg_sel` high after reset), `rd_flag` is 1 when no half can be read. A read strobe made while `rd_flag` is 1 leaves `rd_data` unchanged.
- R4: In standard timing, `wr_flag` is 1 once DEPTH words are stored. A write strobe made while it is 1 is dropped and stores nothing.
- R5: In fall-through timing (`cfg_sel` low after reset), the first half appears on `rd_data` with `rd_flag` at 1 without any read strobe. `rd_flag` returns to 0 once the last stored half has been consumed.
- R6: In fall-through timing, `wr_flag` is 1 while there is room for a word and 0 once DEPTH words are held.
- R7: A transfer on either side happens only on a rising edge with the select (`wr_cs_n` / `rd_cs_n`) low and the enable high. Any other combination changes nothing.
- R8: A stored word frees its slot only when its second half leaves the array. Fetching only its first half keeps the store full.
- R9: Each gray pointer changes in at most one bit per clock of its domain.
- R10: Two clocks after reset release, the flags take these values: in standard timing `rd_flag`=1 and `wr_flag`=0; in fall-through timing `rd_flag`=0 and `wr_flag`=1. Both flags are registered on their own port's clock.
- R11: Halves come out in write order across the whole store, including across pointer wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, asynchronous assert |
| cfg_sel | input | 1 | Byte order while `mrst` is high (1 big, 0 little); timing mode after (1 standard, 0 fall-through) |
| wr_cs_n | input | 1 | Write select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | 36 | Word to store |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| rd_cs_n | input | 1 | Read select, active low |
| rd_en | input | 1 | Read enable, active high |
| rd_data | output | 18 | Half-word output |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |

## Verification
The embedded properties take several things for granted about the inputs. `mrst` is held for several cycles of both clocks. `cfg_sel` keeps its timing-mode level from shortly after release onward. Strobes and data change away from the rising edge of their own clock. The bench enforces this by driving every write-side input on the falling edge of `wclk` and every read-side input on the falling edge of `rclk`. It changes `cfg_sel` only around reset, before any transfer. It sweeps all four combinations of byte order and timing mode, and in each one fills the store, overfills it, and drains it.

// File: rtl/narrowing_fifo_pkg.sv
package narrowing_fifo_pkg;
  // level of cfg_sel after reset release
  typedef enum logic {
    MODE_FALLTHRU = 1'b0,
    MODE_STANDARD = 1'b1
  } tmode_e;
  // level of cfg_sel while master reset is held
  typedef enum logic {
    ORDER_LITTLE = 1'b0,
    ORDER_BIG    = 1'b1
  } border_e;
endpackage

// File: rtl/nf_sync2.sv
module nf_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/nf_wr_ctl.sv
module nf_wr_ctl
  import narrowing_fifo_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic        wclk,
  input  logic        mrst,
  input  logic        cfg_sel,
  input  logic        wr_cs_n,
  input  logic        wr_en,
  input  logic [AW:0] rgray_sync,
  output logic        wr_go,
  output logic [AW-1:0] waddr,
  output logic [AW:0] wgray,
  output logic        wr_flag
);
  logic [AW:0] wbin, wbin_nx, wgray_nx;
  logic        full_q, full_nx, std_mode;

  assign std_mode = (cfg_sel == MODE_STANDARD);
  assign wr_go    = !wr_cs_n && wr_en && !full_q;
  assign wbin_nx  = wbin + {{AW{1'b0}}, wr_go};
  assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);
  // full when write pointer is one lap ahead of the synchronized read pointer
  assign full_nx  = (wgray_nx == {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]});
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge wclk or posedge mrst) begin
    if (mrst) begin
      wbin    <= '0;
      wgray   <= '0;
      full_q  <= 1'b0;
      wr_flag <= 1'b0;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= wgray_nx;
      full_q  <= full_nx;
      wr_flag <= std_mode ? full_nx : !full_nx;
    end
  end

  a_r4_no_overflow: assert property (@(posedge wclk) disable iff (mrst)
    full_q |=> (wbin == $past(wbin)));
  a_r7_write_gate: assert property (@(posedge wclk) disable iff (mrst)
    (wr_cs_n || !wr_en) |=> (wbin == $past(wbin)));
  a_r9_wgray_step: assert property (@(posedge wclk) disable iff (mrst)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/nf_rd_ctl.sv
module nf_rd_ctl
  import narrowing_fifo_pkg::*;
#(
  parameter int AW = 3,
  parameter int WW = 36
) (
  input  logic          rclk,
  input  logic          mrst,
  input  logic          cfg_sel,
  input  logic          rd_cs_n,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_sync,
  input  logic [WW-1:0] mem_word,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [WW/2-1:0] rd_data,
  output logic          rd_flag
);
  localparam int HW = WW / 2;

  logic [AW:0]   rbin, rbin_nx, rgray_nx;
  logic          big_q, half_q, empty_q, empty_nx, ov_q, ov_nx;
  logic          fthru, strobe, consume, fetch, take_upper;
  logic [HW-1:0] half_out;

  // byte order is captured while master reset is held
  always_ff @(posedge rclk) begin
    if (mrst) big_q <= (cfg_sel == ORDER_BIG);
  end

  assign fthru      = (cfg_sel == MODE_FALLTHRU);
  assign strobe     = !rd_cs_n && rd_en;
  assign consume    = fthru && ov_q && strobe;
  assign fetch      = !empty_q && (fthru ? (!ov_q || consume) : strobe);
  assign take_upper = big_q ^ half_q;
  assign half_out   = take_upper ? mem_word[WW-1:HW] : mem_word[HW-1:0];
  // slot is released when the second half leaves the array
  assign rbin_nx    = rbin + {{AW{1'b0}}, (fetch && half_q)};
  assign rgray_nx   = rbin_nx ^ (rbin_nx >> 1);
  assign empty_nx   = (rgray_nx == wgray_sync);
  assign ov_nx      = fthru && (fetch || (ov_q && !consume));
  assign raddr      = rbin[AW-1:0];

  always_ff @(posedge rclk or posedge mrst) begin
    if (mrst) begin
      rbin    <= '0;
      rgray   <= '0;
      half_q  <= 1'b0;
      empty_q <= 1'b1;
      ov_q    <= 1'b0;
      rd_data <= '0;
      rd_flag <= 1'b0;
    end else begin
      rbin    <= rbin_nx;
      rgray   <= rgray_nx;
      empty_q <= empty_nx;
      ov_q    <= ov_nx;
      rd_flag <= fthru ? ov_nx : empty_nx;
      if (fetch) begin
        rd_data <= half_out;
        half_q  <= !half_q;
      end
    end
  end

  a_r3_no_underflow: assert property (@(posedge rclk) disable iff (mrst)
    empty_q |=> ((rbin == $past(rbin)) && $stable(half_q)));
  a_r8_first_half_keeps_slot: assert property (@(posedge rclk) disable iff (mrst)
    (fetch && !half_q) |=> (rbin == $past(rbin)));
  a_r5_output_held: assert property (@(posedge rclk) disable iff (mrst)
    (fthru && ov_q && !strobe) |=> (ov_q && $stable(rd_data)));
  a_r7_read_gate: assert property (@(posedge rclk) disable iff (mrst)
    (!fthru && !strobe) |=> $stable(rd_data));
  a_r9_rgray_step: assert property (@(posedge rclk) disable iff (mrst)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/narrowing_fifo.sv
module narrowing_fifo #(
  parameter int WORD_W = 36,
  parameter int DEPTH  = 8
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst,
  input  logic              cfg_sel,
  input  logic              wr_cs_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_flag,
  input  logic              rd_cs_n,
  input  logic              rd_en,
  output logic [WORD_W/2-1:0] rd_data,
  output logic              rd_flag
);
  localparam int AW = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic              wr_go;
  logic [AW-1:0]     waddr, raddr;
  logic [AW:0]       wgray, rgray, wgray_rs, rgray_ws;

  always_ff @(posedge wclk) begin
    if (wr_go) mem[waddr] <= wr_data;
  end

  nf_sync2 #(.W(AW + 1)) u_w2r (
    .clk(rclk), .rst(mrst), .d(wgray), .q(wgray_rs)
  );
  nf_sync2 #(.W(AW + 1)) u_r2w (
    .clk(wclk), .rst(mrst), .d(rgray), .q(rgray_ws)
  );

  nf_wr_ctl #(.AW(AW)) u_wr (
    .wclk(wclk), .mrst(mrst), .cfg_sel(cfg_sel),
    .wr_cs_n(wr_cs_n), .wr_en(wr_en), .rgray_sync(rgray_ws),
    .wr_go(wr_go), .waddr(waddr), .wgray(wgray), .wr_flag(wr_flag)
  );

  nf_rd_ctl #(.AW(AW), .WW(WORD_W)) u_rd (
    .rclk(rclk), .mrst(mrst), .cfg_sel(cfg_sel),
    .rd_cs_n(rd_cs_n), .rd_en(rd_en), .wgray_sync(wgray_rs),
    .mem_word(mem[raddr]), .raddr(raddr), .rgray(rgray),
    .rd_data(rd_data), .rd_flag(rd_flag)
  );
endmodule

// File: tb/sim_narrowing_fifo.sv
module sim_narrowing_fifo;
  localparam int WW = 36;
  localparam int HW = 18;
  localparam int DEPTH = 8;

  logic wclk = 0, rclk = 0, mrst = 1, cfg_sel = 0;
  logic wr_cs_n = 1, wr_en = 0, rd_cs_n = 1, rd_en = 0;
  logic [WW-1:0] wr_data = '0;
  logic [HW-1:0] rd_data;
  logic wr_flag, rd_flag;
  int total = 0, bad = 0;
  logic std_q;

  always #2.5ns wclk = ~wclk;
  always #3.7ns rclk = ~rclk;

  narrowing_fifo #(.WORD_W(WW), .DEPTH(DEPTH)) u0 (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .cfg_sel(cfg_sel),
    .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_data(wr_data), .wr_flag(wr_flag),
    .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_data(rd_data), .rd_flag(rd_flag)
  );

  function automatic logic [HW-1:0] hi_of(int i, int c);
    return HW'(i * 1031 + c * 97 + 77);
  endfunction
  function automatic logic [HW-1:0] lo_of(int i, int c);
    return HW'((i * 613 + c) ^ 18'h15A5A);
  endfunction

  task automatic chk(input logic [WW-1:0] act, input logic [WW-1:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [WW-1:0] d, input logic cs_n, input logic en);
    @(negedge wclk);
    wr_data = d; wr_cs_n = cs_n; wr_en = en;
    @(negedge wclk);
    wr_cs_n = 1; wr_en = 0;
  endtask

  task automatic rd_half(output logic [HW-1:0] d);
    int n = 0;
    @(negedge rclk);
    while ((std_q ? rd_flag : !rd_flag) && n < 500) begin
      @(negedge rclk); n++;
    end
    if (n >= 500) chk(32'd1, 32'd0, "R11 read wait timeout");
    if (!std_q) d = rd_data;
    rd_cs_n = 0; rd_en = 1;
    @(negedge rclk);
    rd_cs_n = 1; rd_en = 0;
    if (std_q) d = rd_data;
  endtask

  task automatic run(input logic big, input logic std, input int c);
    logic [HW-1:0] got, first, last;
    string ord;
    ord = big ? "R1" : "R2";
    std_q = std;
    mrst = 1; cfg_sel = big;
    repeat (5) @(posedge rclk);
    @(negedge rclk); mrst = 0;
    @(negedge rclk); cfg_sel = std;
    repeat (3) @(negedge rclk);
    @(negedge wclk);
    // R10 flag values after release
    chk(rd_flag, std ? 1 : 0, "R10 rd_flag after reset");
    chk(wr_flag, std ? 0 : 1, "R10 wr_flag after reset");
    // R7 gated writes store nothing
    wr_word({WW{1'b1}}, 1'b1, 1'b1);
    wr_word({WW{1'b1}}, 1'b0, 1'b0);
    for (int i = 0; i < DEPTH; i++) wr_word({hi_of(i, c), lo_of(i, c)}, 1'b0, 1'b1);
    @(negedge wclk);
    chk(wr_flag, std ? 1 : 0, std ? "R4 full after DEPTH words" : "R6 not ready after DEPTH words");
    // R4 write while full is dropped
    wr_word({WW{1'b0}}, 1'b0, 1'b1);
    first = big ? hi_of(0, c) : lo_of(0, c);
    repeat (12) @(negedge rclk);
    if (!std) begin
      chk(rd_flag, 1, "R5 output ready without strobe");
      chk(rd_data, first, "R5 first half falls through");
    end
    // R7 gated read changes nothing
    @(negedge rclk); rd_cs_n = 1; rd_en = 1;
    @(negedge rclk); rd_en = 0;
    @(negedge rclk); rd_cs_n = 0;
    @(negedge rclk); rd_cs_n = 1;
    chk(rd_data, std ? '0 : first, "R7 gated read leaves rd_data");
    repeat (10) @(negedge wclk);
    chk(wr_flag, std ? 1 : 0, "R8 full kept before any half read");
    rd_half(got);
    chk(got, first, {ord, " first half of word0"});
    repeat (10) @(negedge wclk);
    if (std) chk(wr_flag, 1, "R8 first half read keeps slot");
    rd_half(got);
    chk(got, big ? lo_of(0, c) : hi_of(0, c), {ord, " second half of word0"});
    repeat (10) @(negedge wclk);
    chk(wr_flag, std ? 0 : 1, "R8 slot freed after second half");
    last = got;
    for (int i = 1; i < DEPTH; i++) begin
      rd_half(got);
      chk(got, big ? hi_of(i, c) : lo_of(i, c), "R11 order first half");
      rd_half(got);
      chk(got, big ? lo_of(i, c) : hi_of(i, c), "R11 order second half");
      last = got;
    end
    repeat (10) @(negedge rclk);
    chk(rd_flag, std ? 1 : 0, std ? "R3 empty after drain" : "R5 not ready after drain");
    if (std) begin
      @(negedge rclk); rd_cs_n = 0; rd_en = 1;
      @(negedge rclk); rd_cs_n = 1; rd_en = 0;
      chk(rd_data, last, "R3 read on empty ignored");
    end
    // R11 wrap: second lap through the store
    for (int i = 0; i < 3; i++) wr_word({hi_of(i + 40, c), lo_of(i + 40, c)}, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      rd_half(got);
      chk(got, big ? hi_of(i + 40, c) : lo_of(i + 40, c), "R11 wrap first half");
      rd_half(got);
      chk(got, big ? lo_of(i + 40, c) : hi_of(i + 40, c), "R11 wrap second half");
    end
  endtask

  initial begin
    for (int c = 0; c < 4; c++) run(c[0], c[1], c);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500us;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule